// File: doc/BRIEF.md
# Serial Transmitter with Watermarked Character Queue

This block turns queued characters into asynchronous serial frames on a single transmit line. Characters wait in a sixteen-slot queue. The block takes one character from the queue when the line is free and, if flow control is on, when the remote side allows sending. Each frame has a low start bit and then the payload, least significant bit first. The payload may end with a parity bit or a ninth data bit. A high stop period follows, whose length can be set in half-bit steps. All bit timing comes from an external strobe at sixteen times the bit rate. The block ignores the strobe between frames.

Four status flags describe the queue and the line. Software that sees the half-empty flag can write a burst of eight characters without checking again. The empty flag goes high only after the last stop period has finished on the line. A single-cycle flush input discards every queued character. The flush does not cut short a frame that is already on the line.

Top module: `sertx_core`

## Requirements
- R1: After reset `txd` is 1, `st_empty` and `st_half` are 1, and `st_nempty` and `st_full` are 0.
- R2: The queue holds 16 nine-bit characters and sends them in write order. A write while `st_full` is 1 is dropped and is never transmitted.
- R3: With N characters queued: `st_nempty` = (N > 0), `st_half` = (N <= 8), `st_full` = (N == 16).
- R4: `st_empty` is 1 only when the queue holds nothing and the stop period of the last frame has ended. During that last stop period `st_empty` is 0.
- R5: A frame is a 0 start bit and then the payload bits, least significant first. Each bit lasts 16 `tick` strobes. `txd` is 1 whenever no frame is active.
- R6: `frame_mode` selects the payload. 3'b001 sends data[7:0]. 3'b011 sends data[6:0] and then a parity bit. 3'b100 sends data[8:0]. 3'b101 sends data[7:0] and then data[8] as a wake-up bit. 3'b111 sends data[7:0] and then a parity bit. Any other code sends data[7:0].
- R7: With `par_odd` = 0 the parity bit makes the count of ones in the data bits plus the parity bit even. With `par_odd` = 1 that count is odd.
- R8: `stop_sel` sets the stop period to 8, 16, 24 or 32 strobes for codes 00, 01, 10 and 11. The frame length from the start edge to the end of the stop period is 16*(1+payload bits) plus that period.
- R9: While `cts_en` is 1 and `cts` is 0, no new frame starts and queued characters stay queued. While `cts_en` is 0, `cts` has no effect.
- R10: A one-cycle pulse on `flush` empties the queue. The flushed characters are never transmitted. If `flush` and `wr_en` are high in the same cycle, `flush` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle strobe at 16x the bit rate |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 9 | Character to queue |
| flush | input | 1 | Discard every queued character |
| frame_mode | input | 3 | Payload format select |
| stop_sel | input | 2 | Stop period select in half-bit steps |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| cts_en | input | 1 | Enable clear-to-send gating |
| cts | input | 1 | Clear to send, 1 = remote ready |
| txd | output | 1 | Serial line, idle high |
| st_empty | output | 1 | Queue empty and line idle |
| st_half | output | 1 | Queue at most half full |
| st_nempty | output | 1 | Queue holds at least one character |
| st_full | output | 1 | Queue holds 16 characters |

## Verification
The hardest cases to reach are a full queue receiving an extra write, and the last stop period, when the queue is already empty but the line is still busy. Both normally last only a few strobes. The bench turns on clear-to-send gating with `cts` low, so the transmitter cannot drain the queue. It then fills the queue slot by slot, checking the watermark flags after each write, and writes one more character. When `cts` is released, a bench-side receiver counts strobes and decodes sixteen frames in order. At the middle of each final payload bit it samples `st_empty`, which must still be 0 at that point. Frame lengths are measured from the start edge to the rise of `st_empty`, which separates the four stop periods.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   localparam int CHAR_W = 9;
   localparam int PAY_W  = 9;

   localparam logic [2:0] FMT_D8   = 3'b001;
   localparam logic [2:0] FMT_D7P  = 3'b011;
   localparam logic [2:0] FMT_D9   = 3'b100;
   localparam logic [2:0] FMT_D8W  = 3'b101;
   localparam logic [2:0] FMT_D8P  = 3'b111;

   typedef struct packed {
      logic [PAY_W-1:0] bits;
      logic [3:0]       nbits;
   } frame_t;

   typedef enum logic [1:0] {
      SH_IDLE = 2'd0,
      SH_DATA = 2'd1,
      SH_STOP = 2'd2
   } sh_state_e;
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 9,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          pop,
   input  logic          flush,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] level
);
   logic [AW-1:0]       wptr, rptr;
   logic [DEPTH*DW-1:0] flat;
   logic                wr_ok, rd_ok;

   assign wr_ok = wr_en && !flush && (level != CW'(DEPTH));
   assign rd_ok = pop && !flush && (level != '0);

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         logic [DW-1:0] q;
         always_ff @(posedge clk) begin
            if (wr_ok && (wptr == AW'(g)))
               q <= wr_data;
         end
         assign flat[g*DW +: DW] = q;
      end
   endgenerate

   assign rd_data = flat[rptr*DW +: DW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (wr_ok) wptr <= wptr + AW'(1);
         if (rd_ok) rptr <= rptr + AW'(1);
         case ({wr_ok, rd_ok})
            2'b10:   level <= level + CW'(1);
            2'b01:   level <= level - CW'(1);
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
   import sertx_pkg::*;
(
   input  logic [2:0]        mode,
   input  logic              odd,
   input  logic [CHAR_W-1:0] data,
   output frame_t            frame
);
   logic par7, par8;

   assign par7 = (^data[6:0]) ^ odd;
   assign par8 = (^data[7:0]) ^ odd;

   always_comb begin
      case (mode)
         FMT_D7P: begin
            frame.bits  = {1'b0, par7, data[6:0]};
            frame.nbits = 4'd8;
         end
         FMT_D9, FMT_D8W: begin
            frame.bits  = data;
            frame.nbits = 4'd9;
         end
         FMT_D8P: begin
            frame.bits  = {par8, data[7:0]};
            frame.nbits = 4'd9;
         end
         default: begin
            frame.bits  = {1'b0, data[7:0]};
            frame.nbits = 4'd8;
         end
      endcase
   end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
   import sertx_pkg::*;
#(
   parameter int OS   = 16,
   localparam int TW  = $clog2(2*OS),
   localparam int HALF = OS / 2,
   localparam int LW  = $clog2(PAY_W + 2)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       go,
   input  frame_t     frame,
   input  logic [1:0] stop_sel,
   output logic       pop,
   output logic       txd,
   output logic       busy
);
   sh_state_e        state;
   logic [PAY_W:0]   sh;
   logic [LW-1:0]    left;
   logic [TW-1:0]    tcnt;
   logic [TW-1:0]    stop_last;
   logic [TW-1:0]    stop_last_d;

   assign stop_last_d = TW'((32'(stop_sel) + 32'd1) * HALF - 1);
   assign pop  = (state == SH_IDLE) && go;
   assign busy = (state != SH_IDLE);
   assign txd  = (state == SH_DATA) ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SH_IDLE;
         sh        <= '1;
         left      <= '0;
         tcnt      <= '0;
         stop_last <= '0;
      end else begin
         case (state)
            SH_IDLE: begin
               if (go) begin
                  sh        <= {frame.bits, 1'b0};
                  left      <= LW'(frame.nbits) + LW'(1);
                  tcnt      <= '0;
                  stop_last <= stop_last_d;
                  state     <= SH_DATA;
               end
            end
            SH_DATA: begin
               if (tick) begin
                  if (tcnt == TW'(OS - 1)) begin
                     tcnt <= '0;
                     if (left == LW'(1)) begin
                        state <= SH_STOP;
                     end else begin
                        sh   <= {1'b1, sh[PAY_W:1]};
                        left <= left - LW'(1);
                     end
                  end else begin
                     tcnt <= tcnt + TW'(1);
                  end
               end
            end
            SH_STOP: begin
               if (tick) begin
                  if (tcnt == stop_last) begin
                     tcnt  <= '0;
                     state <= SH_IDLE;
                  end else begin
                     tcnt <= tcnt + TW'(1);
                  end
               end
            end
            default: state <= SH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sertx_core.sv
module sertx_core
   import sertx_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int OS    = 16,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [CHAR_W-1:0] wr_data,
   input  logic              flush,
   input  logic [2:0]        frame_mode,
   input  logic [1:0]        stop_sel,
   input  logic              par_odd,
   input  logic              cts_en,
   input  logic              cts,
   output logic              txd,
   output logic              st_empty,
   output logic              st_half,
   output logic              st_nempty,
   output logic              st_full
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sertx_core: DEPTH must be a power of two of at least 2");
      end
      if (OS < 4 || (OS % 2) != 0) begin : g_bad_os
         $error("sertx_core: OS must be even and at least 4");
      end
   endgenerate

   logic [CHAR_W-1:0] head;
   logic [CW-1:0]     level;
   logic              pop, go, tx_busy;
   frame_t            frame;

   assign go = (level != '0) && (!cts_en || cts);

   sertx_fifo #(.DEPTH(DEPTH), .DW(CHAR_W)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .pop     (pop),
      .flush   (flush),
      .rd_data (head),
      .level   (level)
   );

   sertx_framer u_framer (
      .mode  (frame_mode),
      .odd   (par_odd),
      .data  (head),
      .frame (frame)
   );

   sertx_shifter #(.OS(OS)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .go       (go),
      .frame    (frame),
      .stop_sel (stop_sel),
      .pop      (pop),
      .txd      (txd),
      .busy     (tx_busy)
   );

   assign st_nempty = (level != '0);
   assign st_full   = (level == CW'(DEPTH));
   assign st_half   = (level <= CW'(DEPTH / 2));
   assign st_empty  = (level == '0) && !tx_busy;
endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk (
   input logic clk,
   input logic rst_n,
   input logic flush,
   input logic cts_en,
   input logic cts,
   input logic txd,
   input logic tx_busy,
   input logic st_empty,
   input logic st_half,
   input logic st_nempty,
   input logic st_full
);
   // R3: a full queue is neither empty nor half empty
   a_r3_full_flags: assert property (@(posedge clk) disable iff (!rst_n)
      st_full |-> (st_nempty && !st_half));

   // R4: empty means no queued character and an idle line
   a_r4_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
      st_empty |-> (!tx_busy && !st_nempty && txd));

   // R5: line is high outside a frame
   a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd);

   // R9: a frame starts only when sending is allowed
   a_r9_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> $past(!cts_en || cts));

   // R10: a flush leaves the queue empty
   a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !st_nempty);
endmodule

bind sertx_core sertx_core_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flush     (flush),
   .cts_en    (cts_en),
   .cts       (cts),
   .txd       (txd),
   .tx_busy   (tx_busy),
   .st_empty  (st_empty),
   .st_half   (st_half),
   .st_nempty (st_nempty),
   .st_full   (st_full)
);

// File: tb/sertx_core_bench.sv
module sertx_core_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [8:0] wr_data = '0;
   logic       flush = 1'b0;
   logic [2:0] frame_mode = 3'b001;
   logic [1:0] stop_sel = 2'b01;
   logic       par_odd = 1'b0;
   logic       cts_en = 1'b0;
   logic       cts = 1'b0;
   logic       txd, st_empty, st_half, st_nempty, st_full;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   sertx_core u_sertx_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
      .flush(flush), .frame_mode(frame_mode), .stop_sel(stop_sel),
      .par_odd(par_odd), .cts_en(cts_en), .cts(cts), .txd(txd),
      .st_empty(st_empty), .st_half(st_half), .st_nempty(st_nempty),
      .st_full(st_full)
   );

   // strobe every fourth cycle
   initial begin
      forever begin
         repeat (3) @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   end

   int tc = 0;
   always @(posedge clk) if (tick) tc <= tc + 1;

   // bench receiver, strobe-counted, samples mid-bit
   int         cur_n = 8;
   int         rx_st = 0;
   int         rx_base = 0;
   int         rx_idx = 0;
   int         prev_tc = 0;
   int         rx_cnt = 0;
   logic [9:0] rx_buf = '0;
   logic       rx_start = 1'b1;
   logic       rx_te_last = 1'b0;
   logic [9:0] rx_mem [32];

   always @(negedge clk) begin
      if (rst_n) begin
         case (rx_st)
            0: if (!txd) begin
                  rx_base = tc; rx_idx = 0; rx_buf = '0; rx_st = 1;
               end
            1: if (tc != prev_tc && ((tc - rx_base) % 16) == 8) begin
                  if (rx_idx == 0) rx_start = txd;
                  else rx_buf[rx_idx-1] = txd;
                  if (rx_idx == cur_n) begin
                     if (rx_cnt < 32) rx_mem[rx_cnt] = rx_buf;
                     rx_te_last = st_empty;
                     rx_cnt = rx_cnt + 1;
                     rx_st = 2;
                  end else begin
                     rx_idx = rx_idx + 1;
                  end
               end
            default: if (txd) rx_st = 0;
         endcase
      end
      prev_tc = tc;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [9:0] exp_pay(input logic [2:0] m, input logic odd,
                                          input logic [8:0] d, output int n);
      logic [9:0] r;
      case (m)
         3'b011: begin r = {2'b0, ~^{odd, d[6:0]} ^ 1'b1, d[6:0]}; n = 8; end
         3'b100, 3'b101: begin r = {1'b0, d}; n = 9; end
         3'b111: begin r = {1'b0, ~^{odd, d[7:0]} ^ 1'b1, d[7:0]}; n = 9; end
         default: begin r = {2'b0, d[7:0]}; n = 8; end
      endcase
      return r;
   endfunction

   task automatic write_char(input logic [8:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_ticks(input int n);
      int t0;
      t0 = tc;
      while (tc - t0 < n) @(negedge clk);
   endtask

   // {mode, stop, odd, data, frame length in strobes}
   localparam logic [23:0] VEC [8] = '{
      {3'b001, 2'b01, 1'b0, 9'h0A5, 9'd160},
      {3'b011, 2'b00, 1'b0, 9'h053, 9'd152},
      {3'b011, 2'b10, 1'b1, 9'h053, 9'd168},
      {3'b100, 2'b11, 1'b0, 9'h1C3, 9'd192},
      {3'b101, 2'b01, 1'b0, 9'h155, 9'd176},
      {3'b111, 2'b10, 1'b1, 9'h0F0, 9'd184},
      {3'b111, 2'b00, 1'b0, 9'h001, 9'd168},
      {3'b001, 2'b11, 1'b1, 9'h1FF, 9'd176}
   };

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R5 watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      int n0, n, len;
      logic [9:0] ep;
      logic [8:0] vals [16];
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(txd == 1'b1, "R1 txd", int'(txd), 1);
      chk({st_empty, st_half, st_nempty, st_full} == 4'b1100, "R1 flags",
          int'({st_empty, st_half, st_nempty, st_full}), 4'hC);

      // table walk, gating off and cts low: R9 no effect when disabled
      foreach (VEC[i]) begin
         frame_mode = VEC[i][23:21];
         stop_sel   = VEC[i][20:19];
         par_odd    = VEC[i][18];
         ep = exp_pay(VEC[i][23:21], VEC[i][18], VEC[i][17:9], n);
         cur_n = n;
         n0 = rx_cnt;
         write_char(VEC[i][17:9]);
         while (rx_cnt == n0) @(negedge clk);
         chk(rx_start == 1'b0, "R5 start bit", int'(rx_start), 0);
         chk(rx_mem[n0] == ep, "R6 R7 payload", int'(rx_mem[n0]), int'(ep));
         chk(rx_te_last == 1'b0, "R4 empty low in stop", int'(rx_te_last), 0);
         while (!st_empty) @(negedge clk);
         len = tc - rx_base;
         chk(len == int'(VEC[i][8:0]), "R8 frame length", len, int'(VEC[i][8:0]));
      end

      // R9 gating: queue fills while cts held low; R2/R3 watermarks
      frame_mode = 3'b100; stop_sel = 2'b00; par_odd = 1'b0;
      cur_n = 9;
      cts_en = 1'b1; cts = 1'b0;
      n0 = rx_cnt;
      for (int i = 0; i < 16; i++) begin
         vals[i] = 9'((i * 37 + 5) & 9'h1FF);
         write_char(vals[i]);
         chk(st_nempty == 1'b1, "R3 nempty", int'(st_nempty), 1);
         chk(st_half == (i + 1 <= 8), "R3 half", int'(st_half), int'(i + 1 <= 8));
         chk(st_full == (i + 1 == 16), "R3 full", int'(st_full), int'(i + 1 == 16));
      end
      write_char(9'h0AA);
      wait_ticks(100);
      chk(rx_cnt == n0 && txd == 1'b1, "R9 held", rx_cnt - n0, 0);
      chk(st_full == 1'b1, "R2 still full", int'(st_full), 1);
      cts = 1'b1;
      while (!st_empty) @(negedge clk);
      wait_ticks(200);
      chk(rx_cnt - n0 == 16, "R2 frame count", rx_cnt - n0, 16);
      for (int i = 0; i < 16; i++)
         chk(rx_mem[n0 + i] == {1'b0, vals[i]}, "R2 order",
             int'(rx_mem[n0 + i]), int'(vals[i]));

      // R10 flush while held
      cts = 1'b0;
      for (int i = 0; i < 5; i++) write_char(9'h011 + 9'(i));
      chk(st_nempty == 1'b1, "R10 before flush", int'(st_nempty), 1);
      @(negedge clk);
      flush = 1'b1; wr_en = 1'b1; wr_data = 9'h077;
      @(negedge clk);
      flush = 1'b0; wr_en = 1'b0;
      chk({st_empty, st_half, st_nempty} == 3'b110, "R10 flags",
          int'({st_empty, st_half, st_nempty}), 6);
      n0 = rx_cnt;
      cts = 1'b1;
      wait_ticks(300);
      chk(rx_cnt == n0 && txd == 1'b1, "R10 nothing sent", rx_cnt - n0, 0);

      finish_run();
   end
endmodule